// File: doc/BRIEF.md
# Host-Writable Parallel Output Latch

This block holds an output byte in a latch and presents it on a bidirectional parallel port whose drivers are switched on and off apart from the latch contents. The core fills the latch in one of two ways. It can write a pair of nibbles, a memory digit and an accumulator value. It can also write a full byte constant. The core can read the live pin levels back one nibble at a time at any time, whatever the latch holds.

With the host option on, three active-low inputs act as read strobe, chip select and write strobe for an external host processor. A host write captures the byte on the pins into the latch. A host read turns the drivers on so that the host sees the latch. A flag output tells the core that the host has written. The core clears the flag once it has consumed the byte.

Top module: `lport_hostlatch`

## Requirements
- R1: After reset the latch holds 0, the drivers are off (`pad_oe_o` = 0) and `hint_o` is 0.
- R2: With `ld_nib_i` high, the next clock edge loads the latch with `mem_nib_i` in the upper nibble and `acc_nib_i` in the lower nibble.
- R3: With `ld_rom_i` high, the next edge loads the latch with `rom_byte_i`. When both are high in the same cycle, `ld_rom_i` takes precedence over `ld_nib_i`.
- R4: When no load and no host write occurs, the latch keeps its value. `pad_o` always shows the latch.
- R5: A cycle with `drv_set_i` high copies `drv_val_i` into the driver enable, which then persists. `pad_oe_o` is high while that enable is 1.
- R6: `pin_nib_o` returns `pad_i[7:4]` when `pin_hi_sel_i` is 1 and `pad_i[3:0]` when it is 0, whatever the latch and enable hold.
- R7: A falling edge of `host_wr_n_i` while `host_cs_n_i` is low captures `pad_i` into the latch. The inputs pass through a 2-flop synchroniser, so the latch changes on the third clock edge after the strobe falls. A strobe held low captures only once.
- R8: While `host_cs_n_i` is high, activity on `host_wr_n_i` leaves the latch and `hint_o` unchanged.
- R9: While `host_cs_n_i` and `host_rd_n_i` are both low, `pad_oe_o` is high. It rises on the second edge after both fall and drops on the second edge after release, unless R5 holds it on.
- R10: A host write sets `hint_o`. A cycle with `host_ack_i` high clears it. A host write in the same cycle as the clear wins.
- R11: A host write takes precedence over `ld_rom_i` and `ld_nib_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_nib_i | input | 1 | Load latch from memory digit and accumulator |
| mem_nib_i | input | 4 | Memory digit, upper nibble |
| acc_nib_i | input | 4 | Accumulator, lower nibble |
| ld_rom_i | input | 1 | Load latch from byte constant |
| rom_byte_i | input | 8 | Byte constant |
| drv_set_i | input | 1 | Write the driver enable |
| drv_val_i | input | 1 | New driver enable value |
| host_ack_i | input | 1 | Core has read the latch; clears the host flag |
| host_rd_n_i | input | 1 | Host read strobe, active low |
| host_cs_n_i | input | 1 | Host chip select, active low |
| host_wr_n_i | input | 1 | Host write strobe, active low |
| pad_i | input | 8 | Sensed pin levels |
| pad_o | output | 8 | Value presented to the pin drivers |
| pad_oe_o | output | 1 | Pin driver enable |
| pin_hi_sel_i | input | 1 | Selects the pin nibble to read back |
| pin_nib_o | output | 4 | Selected pin nibble |
| hint_o | output | 1 | Host-wrote flag to the host signal line |

## Verification
On every cycle the assertions check latch hold, the nibble and byte loads, capture of the pin byte on a host write pulse, and that the write pulse never lasts two cycles. They also check set and clear of the host flag and that driver enable follows a program write or an active host read. Only the bench scenarios show the latency through the strobe synchroniser and that a chip select held high blocks writes. The same holds for the priority between a host write and a core load in one cycle, and for readback of the pins while the drivers are off.

// File: rtl/lpq_pkg.sv
package lpq_pkg;
   typedef enum logic [1:0] {
      QSRC_HOLD = 2'd0,
      QSRC_NIB  = 2'd1,
      QSRC_ROM  = 2'd2,
      QSRC_HOST = 2'd3
   } qsrc_e;

   // host write beats byte constant beats nibble pair
   function automatic qsrc_e pick_src(input logic host_wr, input logic rom, input logic nib);
      if (host_wr)  return QSRC_HOST;
      else if (rom) return QSRC_ROM;
      else if (nib) return QSRC_NIB;
      else          return QSRC_HOLD;
   endfunction
endpackage

// File: rtl/lpq_sync.sv
module lpq_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpq_host_dec.sv
module lpq_host_dec #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n_i,
   input  logic cs_n_i,
   input  logic wr_n_i,
   output logic wr_pulse_o,
   output logic rd_act_o
);
   logic [2:0] raw, synced;
   logic       rd_s, cs_s, wr_s, wr_prev;

   assign raw = {rd_n_i, cs_n_i, wr_n_i};

   lpq_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (synced)
   );

   assign {rd_s, cs_s, wr_s} = synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b1;
      else        wr_prev <= wr_s;
   end

   assign wr_pulse_o = wr_prev & ~wr_s & ~cs_s;
   assign rd_act_o   = ~rd_s & ~cs_s;

   // R7: one capture per strobe edge
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse_o |=> !wr_pulse_o);
endmodule

// File: rtl/lpq_qreg.sv
module lpq_qreg
   import lpq_pkg::*;
#(
   parameter int DW = 8,
   localparam int NW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_nib_i,
   input  logic [NW-1:0] mem_nib_i,
   input  logic [NW-1:0] acc_nib_i,
   input  logic          ld_rom_i,
   input  logic [DW-1:0] rom_byte_i,
   input  logic          host_wr_i,
   input  logic [DW-1:0] pin_data_i,
   input  logic          ack_i,
   output logic [DW-1:0] q_o,
   output logic          flag_o
);
   qsrc_e         src;
   logic [DW-1:0] q_nxt;

   always_comb begin
      src = pick_src(host_wr_i, ld_rom_i, ld_nib_i);
      unique case (src)
         QSRC_HOST: q_nxt = pin_data_i;
         QSRC_ROM:  q_nxt = rom_byte_i;
         QSRC_NIB:  q_nxt = {mem_nib_i, acc_nib_i};
         default:   q_nxt = q_o;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o    <= '0;
         flag_o <= 1'b0;
      end else begin
         q_o <= q_nxt;
         if (host_wr_i)  flag_o <= 1'b1;
         else if (ack_i) flag_o <= 1'b0;
      end
   end

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr_i || ld_rom_i || ld_nib_i) |=> $stable(q_o));
   a_r2_nib_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_nib_i && !ld_rom_i && !host_wr_i) |=> q_o == {$past(mem_nib_i), $past(acc_nib_i)});
   a_r3_rom_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rom_i && !host_wr_i) |=> q_o == $past(rom_byte_i));
   a_r7_host_capture: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_i |=> q_o == $past(pin_data_i));
   a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_i |=> flag_o);
   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !host_wr_i) |=> !flag_o);
endmodule

// File: rtl/lport_hostlatch.sv
module lport_hostlatch #(
   parameter int DW = 8,
   parameter bit HOST_EN = 1'b1,
   parameter int SYNC_STAGES = 2,
   localparam int NW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_nib_i,
   input  logic [NW-1:0] mem_nib_i,
   input  logic [NW-1:0] acc_nib_i,
   input  logic          ld_rom_i,
   input  logic [DW-1:0] rom_byte_i,
   input  logic          drv_set_i,
   input  logic          drv_val_i,
   input  logic          host_ack_i,
   input  logic          host_rd_n_i,
   input  logic          host_cs_n_i,
   input  logic          host_wr_n_i,
   input  logic [DW-1:0] pad_i,
   output logic [DW-1:0] pad_o,
   output logic          pad_oe_o,
   input  logic          pin_hi_sel_i,
   output logic [NW-1:0] pin_nib_o,
   output logic          hint_o
);
   if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
      $error("lport_hostlatch: DW must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lport_hostlatch: SYNC_STAGES must be at least 2");
   end

   logic host_wr, host_rd_act, drv_en;
   logic [DW-1:0] q;

   generate
      if (HOST_EN) begin : g_host
         lpq_host_dec #(.STAGES(SYNC_STAGES)) i_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_n_i     (host_rd_n_i),
            .cs_n_i     (host_cs_n_i),
            .wr_n_i     (host_wr_n_i),
            .wr_pulse_o (host_wr),
            .rd_act_o   (host_rd_act)
         );
      end else begin : g_nohost
         assign host_wr     = 1'b0;
         assign host_rd_act = 1'b0;
      end
   endgenerate

   lpq_qreg #(.DW(DW)) i_qreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_nib_i   (ld_nib_i),
      .mem_nib_i  (mem_nib_i),
      .acc_nib_i  (acc_nib_i),
      .ld_rom_i   (ld_rom_i),
      .rom_byte_i (rom_byte_i),
      .host_wr_i  (host_wr),
      .pin_data_i (pad_i),
      .ack_i      (host_ack_i),
      .q_o        (q),
      .flag_o     (hint_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         drv_en <= 1'b0;
      else if (drv_set_i) drv_en <= drv_val_i;
   end

   assign pad_o     = q;
   assign pad_oe_o  = drv_en | host_rd_act;
   assign pin_nib_o = pin_hi_sel_i ? pad_i[DW-1:NW] : pad_i[NW-1:0];

   a_r5_drv_on: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_set_i && drv_val_i) |=> pad_oe_o);
   a_r5_drv_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_set_i && pad_oe_o && !host_rd_act) |=> pad_oe_o);
   a_r9_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_act |-> pad_oe_o);
endmodule

// File: tb/test_lport_hostlatch.sv
module test_lport_hostlatch;
   localparam int DW = 8;
   localparam int NW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_nib = 0, ld_rom = 0, drv_set = 0, drv_val = 0, ack = 0;
   logic [NW-1:0] mem_nib = '0, acc_nib = '0;
   logic [DW-1:0] rom_byte = '0, host_bus = '0;
   logic rd_n = 1, cs_n = 1, wr_n = 1, hi_sel = 0;
   logic [DW-1:0] pad_i, pad_o;
   logic pad_oe, hint;
   logic [NW-1:0] pin_nib;
   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   assign pad_i = pad_oe ? pad_o : host_bus;

   lport_hostlatch i_lport_hostlatch (
      .clk(clk), .rst_n(rst_n), .ld_nib_i(ld_nib), .mem_nib_i(mem_nib),
      .acc_nib_i(acc_nib), .ld_rom_i(ld_rom), .rom_byte_i(rom_byte),
      .drv_set_i(drv_set), .drv_val_i(drv_val), .host_ack_i(ack),
      .host_rd_n_i(rd_n), .host_cs_n_i(cs_n), .host_wr_n_i(wr_n),
      .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe),
      .pin_hi_sel_i(hi_sel), .pin_nib_o(pin_nib), .hint_o(hint)
   );

   function automatic logic [DW-1:0] pack_nib(logic [NW-1:0] m, logic [NW-1:0] a);
      return {m, a};
   endfunction

   function automatic logic [NW-1:0] sel_nib(logic [DW-1:0] b, logic hi);
      return hi ? b[7:4] : b[3:0];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] exp_q;
      void'($urandom(32'd1234));
      step(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 latch", pad_o, 0);
      chk("R1 oe", pad_oe, 0);
      chk("R1 hint", hint, 0);

      // R2 nibble pair load
      mem_nib = 4'hA; acc_nib = 4'h5; ld_nib = 1;
      step(); ld_nib = 0;
      chk("R2 nib load", pad_o, 8'hA5);

      // R3 byte load wins over nibble load
      rom_byte = 8'h3C; ld_rom = 1; ld_nib = 1; mem_nib = 4'h1; acc_nib = 4'h2;
      step(); ld_rom = 0; ld_nib = 0;
      chk("R3 rom priority", pad_o, 8'h3C);

      // R4 hold with changing data, no load
      mem_nib = 4'hF; acc_nib = 4'hE; rom_byte = 8'h77;
      step(3);
      chk("R4 hold", pad_o, 8'h3C);

      // R6 readback with drivers off shows the bus, not the latch
      host_bus = 8'h96; hi_sel = 0; #1;
      chk("R6 low nibble", pin_nib, 4'h6);
      hi_sel = 1; #1;
      chk("R6 high nibble", pin_nib, 4'h9);

      // R5 program driver enable
      drv_set = 1; drv_val = 1; step(); drv_set = 0; drv_val = 0;
      chk("R5 oe on", pad_oe, 1);
      step(3);
      chk("R5 oe persists", pad_oe, 1);
      hi_sel = 1; #1;
      chk("R6 readback driven", pin_nib, 4'h3);
      drv_set = 1; drv_val = 0; step(); drv_set = 0;
      chk("R5 oe off", pad_oe, 0);

      // random core loads with readback
      exp_q = 8'h3C;
      for (int i = 0; i < 150; i++) begin
         int op;
         op = $urandom % 3;
         mem_nib = NW'($urandom); acc_nib = NW'($urandom);
         rom_byte = DW'($urandom); host_bus = DW'($urandom);
         hi_sel = 1'($urandom);
         ld_nib = (op == 1) || ($urandom % 4 == 0);
         ld_rom = (op == 2);
         if (ld_rom) exp_q = rom_byte;
         else if (ld_nib) exp_q = pack_nib(mem_nib, acc_nib);
         step(); ld_nib = 0; ld_rom = 0;
         chk(op == 0 && !ld_nib ? "R4 random" : "R2/R3 random", pad_o, exp_q);
         chk("R6 random", pin_nib, sel_nib(host_bus, hi_sel));
      end

      // R7 host write with synchroniser latency
      host_bus = 8'hC4; cs_n = 0; wr_n = 0;
      step(2);
      chk("R7 not yet", pad_o, exp_q);
      step();
      chk("R7 captured", pad_o, 8'hC4);
      chk("R10 hint set", hint, 1);
      host_bus = 8'h21; step(4);
      chk("R7 single capture", pad_o, 8'hC4);
      wr_n = 1; cs_n = 1; step(3);

      // R10 clear by ack
      ack = 1; step(); ack = 0;
      chk("R10 hint clear", hint, 0);

      // R8 chip select high blocks writes
      host_bus = 8'hE7;
      for (int k = 0; k < 3; k++) begin
         wr_n = 0; step(3); wr_n = 1; step(3);
      end
      chk("R8 latch", pad_o, 8'hC4);
      chk("R8 hint", hint, 0);

      // R9 host read enables drivers
      cs_n = 0; rd_n = 0; step();
      chk("R9 not yet", pad_oe, 0);
      step();
      chk("R9 oe", pad_oe, 1);
      hi_sel = 0; #1;
      chk("R9 host sees latch", pin_nib, 4'h4);
      cs_n = 1; rd_n = 1; step();
      chk("R9 still on", pad_oe, 1);
      step();
      chk("R9 released", pad_oe, 0);
      step(2);

      // R11 host write beats rom load; R10 set beats ack
      host_bus = 8'h5A; cs_n = 0; wr_n = 0;
      step(2);
      ld_rom = 1; rom_byte = 8'h11; ack = 1;
      step(); ld_rom = 0; ack = 0;
      chk("R11 host priority", pad_o, 8'h5A);
      chk("R10 set wins", hint, 1);
      wr_n = 1; cs_n = 1; step(3);
      ld_rom = 1; step(); ld_rom = 0;
      chk("R3 rom after host", pad_o, 8'h11);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule